// File: doc/BRIEF.md
# Half-Duplex Clocked Serial Port

This block is an 8-bit synchronous serial port for a processor's I/O space. One data register serves both directions: software writes a byte and sets the transmit enable to send it, or sets the receive enable to collect a byte into the same register. Only one direction runs at a time. At the end of each byte the active enable clears itself, an end flag is raised, and an interrupt follows if software has enabled it.

The serial clock either comes from a divider on the system clock and is driven out on the clock pin, or arrives on that pin from outside. A 3-bit speed field picks the source and the divide ratio. Transmit data changes on the falling edge of the serial clock. Receive data is sampled on the rising edge. Bits move least-significant first. There is no holding buffer, so a write to the data register during a transfer replaces the bits still waiting to be shifted.

Top module: `hdx_serial_port`

## Requirements
- R1: After reset, every field of the control register reads as 00000111: both enables, the end flag and the interrupt enable are 0, and the speed field is 111. The data register reads 0x00, `sck_o` and `sdo` are high, and `irq` is low.
- R2: Address 0 selects the control register and address 1 selects the data register. Control layout: bit 7 is the end flag (read-only), bit 6 is the interrupt enable, bit 5 is the receive enable, bit 4 is the transmit enable, bit 3 reads 0, and bits 2:0 are the speed field.
- R3: For speed codes 0 to 6, `sck_oe` is 1 and `sck_o` has a period of 20·2^code system clocks while a transfer runs. `sck_o` rests high whenever no enable is set.
- R4: A transmit puts data-register bits on `sdo` least-significant first, with one new bit at each falling edge of the serial clock. `sdo` then holds the last bit. A 1 is shifted in behind each bit sent, so the data register reads 0xFF after a whole byte.
- R5: A receive samples `sdi` at each rising edge of the serial clock and shifts it in from the top, least-significant bit first. After 8 bits the data register holds the received byte.
- R6: On the 8th rising edge of a transfer, the active enable clears and the end flag sets. `irq` equals end flag AND interrupt enable.
- R7: Any read or write of the data register clears the end flag, unless a transfer completes in that same cycle.
- R8: While one enable is 1, a control write cannot set the other. A write that asks for both while idle starts only the transmit.
- R9: While `io_stop` is high, both enables are held at 0 and control writes cannot set them.
- R10: A data-register write during a transfer replaces the shift contents at once. The next falling edges send the new bits.
- R11: Speed code 7 selects the external clock. `sck_oe` is 0, and edges of `sck_i` drive the shifting after a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| io_stop | input | 1 | Stop request that forces both enables low |
| sck_o | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Output enable of the serial clock pin |
| sck_i | input | 1 | Serial clock received in external mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The assertions assume that `sdi` is stable around rising serial-clock edges and that `sck_i` stays at each level for several system clocks. They also assume that control writes do not land in the cycle a transfer completes. The stimulus changes `sdi` only just after a falling serial-clock edge and holds each `sck_i` level for eight system clocks. It polls the control register to find the end of a transfer before it writes the next command. A behavioural model computes every output on every clock, and directed checks rebuild the bytes seen on the serial pins.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned DATA_ADDR = 1;
  localparam int unsigned BIT_EF  = 7;
  localparam int unsigned BIT_EIE = 6;
  localparam int unsigned BIT_RE  = 5;
  localparam int unsigned BIT_TE  = 4;
  localparam int unsigned BUS_W   = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_ev_t;
endpackage

// File: rtl/hdx_clkgen.sv
module hdx_clkgen
  import hdx_pkg::*;
#(
  parameter int unsigned SS_W      = 3,
  parameter int unsigned BASE_HALF = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [SS_W-1:0] ss,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            sck_oe,
  output sclk_ev_t        ev
);
  localparam int unsigned TOP_CODE = (1 << SS_W) - 2;
  localparam int unsigned MAX_HALF = BASE_HALF << TOP_CODE;
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

  logic             ext;
  logic             run;
  logic             tick;
  logic [CNT_W-1:0] half_m1;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic [2:0]       sync_q;

  assign ext     = (ss == {SS_W{1'b1}});
  assign run     = active & ~ext;
  assign half_m1 = CNT_W'((BASE_HALF << ss) - 1);
  assign tick    = run & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = half_m1;
      sck_d = 1'b1;
    end else if (tick) begin
      cnt_d = half_m1;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sck_q  <= 1'b1;
      sync_q <= 3'b111;
    end else begin
      cnt_q  <= cnt_d;
      sck_q  <= sck_d;
      sync_q <= {sync_q[1:0], sck_i};
    end
  end

  always_comb begin
    if (ext) begin
      ev.rise = active & sync_q[1] & ~sync_q[2];
      ev.fall = active & ~sync_q[1] & sync_q[2];
    end else begin
      ev.rise = tick & ~sck_q;
      ev.fall = tick & sck_q;
    end
  end

  assign sck_o  = sck_q;
  assign sck_oe = ~ext;
endmodule

// File: rtl/hdx_shifter.sv
module hdx_shifter
  import hdx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          te,
  input  logic          re,
  input  sclk_ev_t      ev,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          sdi,
  output logic          sdo,
  output logic [DW-1:0] shreg,
  output logic          done
);
  localparam int unsigned BC_W = $clog2(DW);
  localparam logic [BC_W-1:0] LAST = BC_W'(DW - 1);

  logic [DW-1:0]   sh_q, sh_d;
  logic            sdo_q, sdo_d;
  logic [BC_W-1:0] bc_q, bc_d;
  logic            busy;

  assign busy = te | re;
  assign done = busy & ev.rise & (bc_q == LAST);

  always_comb begin
    sh_d  = sh_q;
    sdo_d = sdo_q;
    if (load) begin
      sh_d = load_val;
    end else if (te && ev.fall) begin
      sh_d = {1'b1, sh_q[DW-1:1]};
    end else if (re && ev.rise) begin
      sh_d = {sdi, sh_q[DW-1:1]};
    end
    if (te && ev.fall) begin
      sdo_d = sh_q[0];
    end
  end

  always_comb begin
    if (!busy) begin
      bc_d = '0;
    end else if (ev.rise) begin
      bc_d = bc_q + 1'b1;
    end else begin
      bc_d = bc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      sdo_q <= 1'b1;
      bc_q  <= '0;
    end else begin
      sh_q  <= sh_d;
      sdo_q <= sdo_d;
      bc_q  <= bc_d;
    end
  end

  assign sdo   = sdo_q;
  assign shreg = sh_q;
endmodule

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
  import hdx_pkg::*;
#(
  parameter int unsigned SS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [BUS_W-1:0] wdata,
  input  logic             data_acc,
  input  logic             done,
  input  logic             io_stop,
  output logic             te,
  output logic             re,
  output logic             ef,
  output logic             eie,
  output logic [SS_W-1:0]  ss
);
  logic            te_q, te_d, re_q, re_d, ef_q, ef_d, eie_q, eie_d;
  logic [SS_W-1:0] ss_q, ss_d;
  logic            te_req, re_req;

  assign te_req = wdata[BIT_TE];
  assign re_req = wdata[BIT_RE];

  always_comb begin
    te_d  = te_q;
    re_d  = re_q;
    eie_d = eie_q;
    ss_d  = ss_q;
    if (wr_ctrl) begin
      eie_d = wdata[BIT_EIE];
      ss_d  = wdata[SS_W-1:0];
    end
    if (io_stop || done) begin
      te_d = 1'b0;
      re_d = 1'b0;
    end else if (wr_ctrl) begin
      te_d = te_req & ~re_q;
      re_d = re_req & ~te_q & ~(te_req & ~re_q);
    end
  end

  always_comb begin
    if (done) begin
      ef_d = 1'b1;
    end else if (data_acc) begin
      ef_d = 1'b0;
    end else begin
      ef_d = ef_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q  <= 1'b0;
      re_q  <= 1'b0;
      ef_q  <= 1'b0;
      eie_q <= 1'b0;
      ss_q  <= {SS_W{1'b1}};
    end else begin
      te_q  <= te_d;
      re_q  <= re_d;
      ef_q  <= ef_d;
      eie_q <= eie_d;
      ss_q  <= ss_d;
    end
  end

  assign te  = te_q;
  assign re  = re_q;
  assign ef  = ef_q;
  assign eie = eie_q;
  assign ss  = ss_q;
endmodule

// File: rtl/hdx_serial_port.sv
module hdx_serial_port
  import hdx_pkg::*;
#(
  parameter int unsigned SS_W      = 3,
  parameter int unsigned BASE_HALF = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       io_stop,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       sdo,
  input  logic       sdi,
  output logic       irq
);
  localparam int unsigned DW = BUS_W;
  localparam int unsigned PAD_W = BIT_TE - SS_W;

  logic            rst_s1, rst_sync_n;
  logic            te, re, ef, eie, done;
  logic [SS_W-1:0] ss;
  logic            wr_ctrl, wr_data, data_acc;
  logic [DW-1:0]   shreg;
  sclk_ev_t        ev;
  logic            unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == 1'(CTRL_ADDR));
  assign wr_data  = bus_sel & bus_wr & (bus_addr == 1'(DATA_ADDR));
  assign data_acc = bus_sel & (bus_addr == 1'(DATA_ADDR));
  assign unused_wbits = ^bus_wdata[BIT_EF:BIT_EF] ^ ^bus_wdata[BIT_TE-1:SS_W];

  hdx_ctrl #(.SS_W(SS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .data_acc(data_acc), .done(done), .io_stop(io_stop),
    .te(te), .re(re), .ef(ef), .eie(eie), .ss(ss)
  );

  hdx_clkgen #(.SS_W(SS_W), .BASE_HALF(BASE_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_sync_n), .active(te | re), .ss(ss),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ev(ev)
  );

  hdx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .te(te), .re(re), .ev(ev),
    .load(wr_data), .load_val(bus_wdata), .sdi(sdi),
    .sdo(sdo), .shreg(shreg), .done(done)
  );

  always_comb begin
    if (bus_addr == 1'(DATA_ADDR)) begin
      bus_rdata = shreg;
    end else begin
      bus_rdata = {ef, eie, re, te, {PAD_W{1'b0}}, ss};
    end
  end

  assign irq = ef & eie;
endmodule

// File: rtl/hdx_serial_port_chk.sv
module hdx_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic te,
  input logic re,
  input logic ef,
  input logic done,
  input logic data_acc,
  input logic io_stop,
  input logic fall,
  input logic sck_o,
  input logic sdo
);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n) !(te && re));
  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!te && !re && ef));
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n) io_stop |=> (!te && !re));
  p_efclr_r7: assert property (@(posedge clk) disable iff (!rst_n) (data_acc && !done) |=> !ef);
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) !(te || re) |=> sck_o);
  p_sdo_r4: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sdo) |-> $past(te && fall));
endmodule

bind hdx_serial_port hdx_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .te(te), .re(re), .ef(ef), .done(done),
  .data_acc(data_acc), .io_stop(io_stop), .fall(ev.fall), .sck_o(sck_o), .sdo(sdo)
);

// File: tb/tb_hdx_serial_port.sv
module tb_hdx_serial_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic io_stop = 0, sck_i = 1, sdi = 0;
  logic sck_o, sck_oe, sdo, irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hdx_serial_port dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising clock
  int m_r1 = 0, m_r2 = 0, m_te, m_re, m_ef, m_eie, m_ss, m_sh, m_sdo, m_sck, m_left, m_nb;
  int h1, h2, h3;
  always @(posedge clk) begin
    int act, ext, tick, rise, fall, done, wc, wd, da, te_n, re_n;
    if (!rst_n || !m_r2) begin
      m_te = 0; m_re = 0; m_ef = 0; m_eie = 0; m_ss = 7; m_sh = 0; m_sdo = 1;
      m_sck = 1; m_left = 0; m_nb = 0; h1 = 1; h2 = 1; h3 = 1;
    end else begin
      act = m_te | m_re; ext = (m_ss == 7);
      tick = act && !ext && m_left == 0;
      rise = ext ? (act && h2 && !h3) : (tick && !m_sck);
      fall = ext ? (act && !h2 && h3) : (tick && m_sck);
      done = act && rise && m_nb == 7;
      wc = bus_sel && bus_wr && !bus_addr;
      wd = bus_sel && bus_wr && bus_addr;
      da = bus_sel && bus_addr;
      if (m_te && fall) m_sdo = m_sh & 1;
      if (wd) m_sh = bus_wdata;
      else if (m_te && fall) m_sh = (m_sh >> 1) | 8'h80;
      else if (m_re && rise) m_sh = (m_sh >> 1) | (sdi << 7);
      m_nb = !act ? 0 : (rise ? (m_nb + 1) % 8 : m_nb);
      if (!act || ext) begin m_left = (10 << m_ss) - 1; m_sck = 1; end
      else if (m_left == 0) begin m_left = (10 << m_ss) - 1; m_sck = !m_sck; end
      else m_left--;
      te_n = m_te; re_n = m_re;
      if (io_stop || done) begin te_n = 0; re_n = 0; end
      else if (wc) begin
        te_n = bus_wdata[4] && !m_re;
        re_n = bus_wdata[5] && !m_te && !(bus_wdata[4] && !m_re);
      end
      if (wc) begin m_eie = bus_wdata[6]; m_ss = bus_wdata[2:0]; end
      if (done) m_ef = 1; else if (da) m_ef = 0;
      m_te = te_n; m_re = re_n;
      h3 = h2; h2 = h1; h1 = sck_i;
    end
    m_r2 = rst_n ? m_r1 : 0; m_r1 = rst_n ? 1 : 0;
  end

  always @(negedge clk) begin
    if (rst_n && m_r2) begin
      chk("R4", "sdo", sdo, m_sdo);
      chk("R3", "sck_o", sck_o, m_sck);
      chk("R11", "sck_oe", sck_oe, m_ss != 7);
      chk("R6", "irq", irq, m_ef & m_eie);
      chk("R2", "rdata", bus_rdata,
          bus_addr ? m_sh : ((m_ef << 7) | (m_eie << 6) | (m_re << 5) | (m_te << 4) | m_ss));
    end
  end

  task automatic bus_write(input bit a, input logic [7:0] d);
    @(negedge clk); #2;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #2;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input bit a, output logic [7:0] d);
    @(negedge clk); #2;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    #2 bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    do bus_read(0, v); while (v[5:4] != 0);
  endtask

  task automatic cap_tx(output logic [7:0] b);
    logic p;
    p = sck_o;
    for (int i = 0; i < 8; i++) begin
      forever begin
        @(negedge clk);
        if (sck_o && !p) break;
        p = sck_o;
      end
      p = sck_o;
      b[i] = sdo;
    end
  endtask

  task automatic drive_rx(input logic [7:0] b);
    logic p;
    p = sck_o;
    for (int i = 0; i < 8; i++) begin
      forever begin
        @(negedge clk);
        if (!sck_o && p) break;
        p = sck_o;
      end
      p = sck_o;
      #2 sdi = b[i];
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, c;
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    bus_read(0, v); chk("R1", "ctrl after reset", v, 8'h07);
    bus_read(1, v); chk("R1", "data after reset", v, 8'h00);
    chk("R1", "sck_o idle", sck_o, 1); chk("R1", "sdo idle", sdo, 1);
    chk("R1", "irq idle", irq, 0);

    // R4/R6: transmit 0xA5, speed 0, interrupt enabled
    bus_write(0, 8'h40);
    bus_write(1, 8'hA5);
    fork
      cap_tx(c);
      bus_write(0, 8'h50);
    join
    chk("R4", "tx byte on sdo", c, 8'hA5);
    repeat (15) @(negedge clk);
    bus_read(0, v); chk("R6", "ctrl after tx", v, 8'hC0);
    chk("R6", "irq after tx", irq, 1);
    bus_read(1, v); chk("R4", "data after tx", v, 8'hFF);
    bus_read(0, v); chk("R7", "ef cleared by data read", v, 8'h40);

    // R3: clock period at speed 2
    bus_write(0, 8'h12);
    begin
      logic p;
      p = sck_o; per = 0;
      for (int k = 0; k < 2; k++) begin
        forever begin
          @(negedge clk);
          if (k == 1) per++;
          if (sck_o && !p) break;
          p = sck_o;
        end
        p = sck_o;
      end
    end
    chk("R3", "sck period speed 2", per, 80);
    wait_idle();
    bus_read(1, v);

    // R5/R8: receive 0x3C at speed 1, try to add transmit meanwhile
    bus_write(0, 8'h21);
    fork
      drive_rx(8'h3C);
      begin
        repeat (50) @(negedge clk);
        bus_write(0, 8'h31);
        bus_read(0, v); chk("R8", "te blocked during rx", v, 8'h21);
      end
    join
    wait_idle();
    bus_read(1, v); chk("R5", "rx byte", v, 8'h3C);
    bus_write(0, 8'h30);
    bus_read(0, v); chk("R8", "both requested from idle", v, 8'h10);
    wait_idle();
    bus_read(1, v);

    // R9: io_stop aborts and blocks
    bus_write(1, 8'h55);
    bus_write(0, 8'h10);
    repeat (30) @(negedge clk);
    #2 io_stop = 1;
    bus_read(0, v); chk("R9", "te forced low", v, 8'h00);
    bus_write(0, 8'h10);
    bus_read(0, v); chk("R9", "te set blocked", v, 8'h00);
    #2 io_stop = 0;
    repeat (4) @(negedge clk);

    // R10: overwrite data after two bits
    bus_write(1, 8'h0F);
    fork
      cap_tx(c);
      begin
        bus_write(0, 8'h10);
        begin
          logic p;
          p = sck_o;
          for (int k = 0; k < 2; k++) begin
            forever begin
              @(negedge clk);
              if (sck_o && !p) break;
              p = sck_o;
            end
            p = sck_o;
          end
        end
        bus_write(1, 8'hF0);
      end
    join
    chk("R10", "spliced tx byte", c, 8'hC3);
    wait_idle();
    bus_read(1, v);

    // R11: external clock
    bus_write(1, 8'h96);
    bus_write(0, 8'h17);
    chk("R11", "sck_oe external", sck_oe, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #2 sck_i = 0;
      repeat (8) @(negedge clk);
      c[i] = sdo;
      #2 sck_i = 1;
      repeat (7) @(negedge clk);
    end
    chk("R11", "ext tx byte", c, 8'h96);
    repeat (6) @(negedge clk);
    bus_read(0, v); chk("R11", "ctrl after ext tx", v, 8'h87);

    finished = 1;
    summary();
    $finish;
  end
endmodule